// File: doc/BRIEF.md
# Overcurrent Repeat-Fault Latch Counter

This block watches for repeated discharge overcurrent trips from several protection channels and escalates them into a latched fault. Each channel delivers a one-cycle trip pulse when its own fault fires. Every pulse adds one to a leaky counter. Once all channels report that their faults are clear, the counter drains by one step for each full quiet period in which no new trip arrives. The quiet period is counted in ticks of a shared time base.

When the count reaches a programmable limit, the block sets a latched fault. When autonomous control is enabled, it also requests that the discharge FET be turned off. Normal channel recovery does not clear this latch. Three sources can clear it: a load-removed report, a host recover strobe, or a qualified charging current. A charging current qualifies only when it is enabled, the charge FET is on, and the current stays above a threshold for a set number of ticks. Clearing the latch also empties the counter. The FET-off request is held until the latch is clear and every channel fault has also cleared.

Top module: `oc_repeat_latch`

## Requirements
- R1: Each trip bit set in a cycle adds one to the count. Several channels tripping in the same cycle add the number of set bits. The count is visible through when the latch sets.
- R2: The count saturates at 2^CNT_W-1 and never wraps. With the count at 14, three simultaneous trips must still set the latch when the limit is 15.
- R3: `alert_o` is 1 exactly when the count is nonzero and the latch is clear. All outputs are 0 after reset.
- R4: The latch sets on the clock edge after the count is nonzero and greater than or equal to `limit_i`. `alert_o` drops at the same time.
- R5: When the latch sets while `fet_auto_i` is 1, `fet_off_o` rises on the same edge.
- R6: The count drains only while `ch_clear_i` is 1, the latch is clear and the count is above zero. It drops by one after each run of `dec_delay_i` ticks with no trip, where a value of 0 acts as 1. It stops at zero, and no tick means no progress.
- R7: A trip arriving during a quiet period restarts that period's tick count from zero.
- R8: If a trip and a period expiry fall in the same cycle, the increment wins and no decrement occurs.
- R9: `load_gone_i`, while latched, clears the latch and zeroes the count on the next edge.
- R10: `host_rcv_i`, while latched, clears the latch and zeroes the count on the next edge.
- R11: Charge recovery clears the latch and the count. It requires `chg_rcv_en_i`, `chg_fet_on_i` and a signed `cur_i` strictly above `rcv_thresh_i` for `rcv_time_i` consecutive ticks, where 0 acts as 1. Any cycle that breaks the condition restarts the run.
- R12: `fet_off_o` falls only on an edge where the latch is clear and `ch_clear_i` is 1. Otherwise it holds.
- R13: Load-removed, host and charge recovery inputs have no effect while the latch is clear. In particular, they do not zero the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_i | input | N_CH | One-cycle trip pulse per channel |
| ch_clear_i | input | 1 | All channel faults are clear |
| limit_i | input | CNT_W | Count at which the latch sets |
| dec_delay_i | input | DLY_W | Quiet period length in ticks |
| tick_i | input | 1 | Time base enable |
| fet_auto_i | input | 1 | Autonomous FET control enable |
| load_gone_i | input | 1 | Load-removed report |
| cur_i | input | CUR_W | Signed current sample |
| rcv_thresh_i | input | CUR_W | Signed charge recovery threshold |
| rcv_time_i | input | RCV_W | Charge recovery time in ticks |
| chg_rcv_en_i | input | 1 | Charge recovery allowed |
| chg_fet_on_i | input | 1 | Charge FET enabled |
| host_rcv_i | input | 1 | Host recover strobe |
| alert_o | output | 1 | Count nonzero, not latched |
| latch_o | output | 1 | Latched repeat fault |
| fet_off_o | output | 1 | Discharge FET off request |

## Verification
Two events collide in this block: a trip pulse and the expiry of a quiet period, which can land on the same clock edge. The bench provokes this by placing a second trip at every offset from zero up to beyond the period length, with the period at two ticks, so that one offset hits the expiry exactly. A behavioural reference model runs alongside the design and judges every cycle. A decrement lost in favour of the increment shows up later as an earlier or later latch and a different alert.

// File: rtl/oc_rl_pkg.sv
package oc_rl_pkg;
  typedef struct packed {
    logic load;
    logic host;
    logic chg;
  } clr_src_t;

  function automatic logic any_src(input clr_src_t s);
    return s.load | s.host | s.chg;
  endfunction
endpackage

// File: rtl/oc_rl_count.sv
module oc_rl_count #(
  parameter int N_CH  = 3,
  parameter int CNT_W = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CH-1:0]  trip_i,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             ch_clear_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] dec_delay_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int SUM_W = CNT_W + $clog2(N_CH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_sat;
  logic [DLY_W-1:0] tmr_q;
  logic [SUM_W-1:0] sum_w;
  logic [DLY_W:0]   tmr_next;
  logic             trip_any, decay_arm, expire;

  always_comb begin
    trip_any  = |trip_i;
    sum_w     = SUM_W'(cnt_q) + SUM_W'($countones(trip_i));
    cnt_sat   = (sum_w > SUM_W'(CNT_MAX)) ? CNT_MAX : sum_w[CNT_W-1:0];
    decay_arm = ch_clear_i && !hold_i && (cnt_q != '0) && !trip_any;
    tmr_next  = {1'b0, tmr_q} + 1'b1;
    expire    = decay_arm && tick_i && (tmr_next >= {1'b0, dec_delay_i});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tmr_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      tmr_q <= '0;
    end else if (trip_any) begin
      cnt_q <= cnt_sat;
      tmr_q <= '0;
    end else if (!decay_arm) begin
      tmr_q <= '0;
    end else if (expire) begin
      cnt_q <= cnt_q - 1'b1;
      tmr_q <= '0;
    end else if (tick_i) begin
      tmr_q <= tmr_next[DLY_W-1:0];
    end
  end

  assign cnt_o = cnt_q;

  assert_no_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && trip_any && !clr_i) |=> cnt_q == CNT_MAX);
  assert_inc_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (trip_any && !clr_i) |=> (cnt_q > $past(cnt_q)) || ($past(cnt_q) == CNT_MAX));
  assert_one_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!trip_any && !clr_i) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1));
  assert_zero_on_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/oc_rl_recover.sv
module oc_rl_recover #(
  parameter int CUR_W = 16,
  parameter int RCV_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    arm_i,
  input  logic                    tick_i,
  input  logic signed [CUR_W-1:0] cur_i,
  input  logic signed [CUR_W-1:0] thr_i,
  input  logic [RCV_W-1:0]        rcv_time_i,
  output logic                    done_o
);
  logic [RCV_W-1:0] run_q;
  logic [RCV_W:0]   run_next;
  logic             qual;

  always_comb begin
    qual     = arm_i && (cur_i > thr_i);
    run_next = {1'b0, run_q} + 1'b1;
    done_o   = qual && tick_i && (run_next >= {1'b0, rcv_time_i});
  end

  always_ff @(posedge clk) begin
    if (rst || !qual || done_o) run_q <= '0;
    else if (tick_i)            run_q <= run_next[RCV_W-1:0];
  end

  assert_run_needs_qual_R11: assert property (@(posedge clk) disable iff (rst)
    (run_q != '0) |-> $past(qual));
endmodule

// File: rtl/oc_rl_latch.sv
module oc_rl_latch
  import oc_rl_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] limit_i,
  input  clr_src_t         src_i,
  input  logic             fet_auto_i,
  input  logic             ch_clear_i,
  output logic             clr_o,
  output logic             latch_o,
  output logic             fet_off_o
);
  logic latch_q, latch_d, fet_q, set_w;

  always_comb begin
    clr_o   = latch_q && any_src(src_i);
    set_w   = !latch_q && (cnt_i != '0) && (cnt_i >= limit_i);
    latch_d = clr_o ? 1'b0 : (set_w ? 1'b1 : latch_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b0;
      fet_q   <= 1'b0;
    end else begin
      latch_q <= latch_d;
      if (latch_d && fet_auto_i)       fet_q <= 1'b1;
      else if (!latch_d && ch_clear_i) fet_q <= 1'b0;
    end
  end

  assign latch_o   = latch_q;
  assign fet_off_o = fet_q;

  assert_latch_on_limit_R4: assert property (@(posedge clk) disable iff (rst)
    (!latch_q && cnt_i != '0 && cnt_i >= limit_i) |=> latch_q);
  assert_fet_with_latch_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(latch_q) && $past(fet_auto_i)) |-> fet_q);
  assert_fet_held_R12: assert property (@(posedge clk) disable iff (rst)
    (fet_q && !ch_clear_i) |=> fet_q);
  assert_idle_sources_R13: assert property (@(posedge clk) disable iff (rst)
    !latch_q |-> !clr_o);
endmodule

// File: rtl/oc_repeat_latch.sv
module oc_repeat_latch
  import oc_rl_pkg::*;
#(
  parameter int N_CH  = 3,
  parameter int CNT_W = 4,
  parameter int DLY_W = 8,
  parameter int CUR_W = 16,
  parameter int RCV_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_CH-1:0]         trip_i,
  input  logic                    ch_clear_i,
  input  logic [CNT_W-1:0]        limit_i,
  input  logic [DLY_W-1:0]        dec_delay_i,
  input  logic                    tick_i,
  input  logic                    fet_auto_i,
  input  logic                    load_gone_i,
  input  logic signed [CUR_W-1:0] cur_i,
  input  logic signed [CUR_W-1:0] rcv_thresh_i,
  input  logic [RCV_W-1:0]        rcv_time_i,
  input  logic                    chg_rcv_en_i,
  input  logic                    chg_fet_on_i,
  input  logic                    host_rcv_i,
  output logic                    alert_o,
  output logic                    latch_o,
  output logic                    fet_off_o
);
  logic [CNT_W-1:0] cnt;
  logic             clr, chg_done, latched;
  clr_src_t         src;

  assign src = '{load: load_gone_i, host: host_rcv_i, chg: chg_done};

  oc_rl_count #(.N_CH(N_CH), .CNT_W(CNT_W), .DLY_W(DLY_W)) u_count (
    .clk(clk), .rst(rst), .trip_i(trip_i), .clr_i(clr), .hold_i(latched),
    .ch_clear_i(ch_clear_i), .tick_i(tick_i), .dec_delay_i(dec_delay_i),
    .cnt_o(cnt)
  );

  oc_rl_recover #(.CUR_W(CUR_W), .RCV_W(RCV_W)) u_recover (
    .clk(clk), .rst(rst),
    .arm_i(latched && chg_rcv_en_i && chg_fet_on_i),
    .tick_i(tick_i), .cur_i(cur_i), .thr_i(rcv_thresh_i),
    .rcv_time_i(rcv_time_i), .done_o(chg_done)
  );

  oc_rl_latch #(.CNT_W(CNT_W)) u_latch (
    .clk(clk), .rst(rst), .cnt_i(cnt), .limit_i(limit_i), .src_i(src),
    .fet_auto_i(fet_auto_i), .ch_clear_i(ch_clear_i), .clr_o(clr),
    .latch_o(latched), .fet_off_o(fet_off_o)
  );

  assign latch_o = latched;
  assign alert_o = (cnt != '0) && !latched;
endmodule

// File: tb/sim_oc_repeat_latch.sv
module sim_oc_repeat_latch;
  localparam int MAXC = 15;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst = 1'b1;
  logic [2:0]        trip = '0;
  logic              ch_clear = 1'b0, tick = 1'b1, fet_auto = 1'b1;
  logic              load = 1'b0, host = 1'b0, chg_en = 1'b0, chg_fet = 1'b0;
  logic [3:0]        limit = 4'd5;
  logic [7:0]        dly = 8'd3, rtime = 8'd3;
  logic signed [15:0] cur = '0, thr = '0;
  logic alert, latch, fet;

  oc_repeat_latch u0 (
    .clk(clk), .rst(rst), .trip_i(trip), .ch_clear_i(ch_clear),
    .limit_i(limit), .dec_delay_i(dly), .tick_i(tick), .fet_auto_i(fet_auto),
    .load_gone_i(load), .cur_i(cur), .rcv_thresh_i(thr), .rcv_time_i(rtime),
    .chg_rcv_en_i(chg_en), .chg_fet_on_i(chg_fet), .host_rcv_i(host),
    .alert_o(alert), .latch_o(latch), .fet_off_o(fet)
  );

  int tests = 0, fails = 0;
  string cur_req = "R3";
  bit done_flag = 0;

  int m_cnt, m_tmr, m_rcv;
  bit m_latch, m_fet;

  always @(posedge clk) begin
    int n, nc, nt, nr;
    bit qual, dn, clr, set, nl, nf;
    if (rst) begin
      m_cnt = 0; m_tmr = 0; m_rcv = 0; m_latch = 0; m_fet = 0;
    end else begin
      n = $countones(trip);
      qual = m_latch && chg_en && chg_fet && (cur > thr);
      dn = 0; nr = 0;
      if (qual && tick) begin
        if (m_rcv + 1 >= int'(rtime)) dn = 1; else nr = m_rcv + 1;
      end else if (qual) nr = m_rcv;
      clr = m_latch && (load || host || dn);
      set = !m_latch && m_cnt != 0 && m_cnt >= int'(limit);
      nc = m_cnt; nt = m_tmr;
      if (clr) begin nc = 0; nt = 0; end
      else if (n > 0) begin nc = (m_cnt + n > MAXC) ? MAXC : m_cnt + n; nt = 0; end
      else if (!(ch_clear && !m_latch && m_cnt != 0)) nt = 0;
      else if (tick) begin
        if (m_tmr + 1 >= int'(dly)) begin nc = m_cnt - 1; nt = 0; end
        else nt = m_tmr + 1;
      end
      nl = clr ? 1'b0 : (set ? 1'b1 : m_latch);
      if (nl && fet_auto) nf = 1;
      else if (!nl && ch_clear) nf = 0;
      else nf = m_fet;
      m_cnt = nc; m_tmr = nt; m_rcv = nr; m_latch = nl; m_fet = nf;
    end
  end

  task automatic chk(input string what, input logic act, input bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done_flag) begin
      chk("alert", alert, rst ? 1'b0 : (m_cnt != 0 && !m_latch));
      chk("latch", latch, rst ? 1'b0 : m_latch);
      chk("fet_off", fet, rst ? 1'b0 : m_fet);
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
    trip = '0; host = 1'b0; load = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic hit(input logic [2:0] m);
    trip = m;
    step();
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    cur_req = "R3"; idle(2);
    cur_req = "R1";
    hit(3'b001); idle(1); hit(3'b010); hit(3'b100); idle(2); hit(3'b001);
    cur_req = "R4"; hit(3'b010); idle(3);
    cur_req = "R5"; idle(2);
    cur_req = "R10"; host = 1'b1; step(); idle(2);
    cur_req = "R12"; idle(2); ch_clear = 1'b1; idle(2);
    cur_req = "R6"; limit = 4'd15; dly = 8'd3;
    hit(3'b001); hit(3'b011); idle(20);
    dly = 8'd0; hit(3'b110); idle(5);
    hit(3'b001); tick = 1'b0; idle(6); tick = 1'b1; idle(4);
    cur_req = "R7"; dly = 8'd5; hit(3'b001); hit(3'b001);
    for (int r = 0; r < 3; r++) begin idle(3); hit(3'b100); end
    idle(30);
    cur_req = "R8"; dly = 8'd2;
    for (int off = 0; off < 5; off++) begin
      hit(3'b001); hit(3'b001); idle(off); hit(3'b010); idle(8);
    end
    cur_req = "R2"; ch_clear = 1'b0; limit = 4'd15;
    for (int i = 0; i < 14; i++) hit(3'b001);
    hit(3'b111); idle(3);
    cur_req = "R9"; load = 1'b1; step(); idle(3);
    cur_req = "R13"; limit = 4'd4;
    hit(3'b001); hit(3'b001); host = 1'b1; step(); load = 1'b1; step();
    chg_en = 1'b1; chg_fet = 1'b1; cur = 16'sd100; idle(5); cur = 16'sd0;
    hit(3'b010); hit(3'b010); idle(3);
    cur_req = "R11"; chg_en = 1'b0; cur = 16'sd100; idle(6);
    chg_en = 1'b1; chg_fet = 1'b0; idle(6); chg_fet = 1'b1;
    cur = 16'sd0; idle(3); cur = 16'sd100; idle(2); cur = 16'sd0; idle(2);
    cur = -16'sd5; thr = -16'sd10; tick = 1'b0; idle(4); tick = 1'b1; idle(6);
    cur = 16'sd0; thr = 16'sd0; chg_en = 1'b0; ch_clear = 1'b1; idle(3);
    cur_req = "random";
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        limit = 4'($urandom_range(1, 15));
        dly = 8'($urandom_range(0, 4));
        rtime = 8'($urandom_range(0, 3));
        fet_auto = 1'($urandom);
      end
      trip = ($urandom % 5 == 0) ? 3'($urandom) : 3'b000;
      host = ($urandom % 60 == 0);
      load = ($urandom % 60 == 0);
      tick = 1'($urandom);
      ch_clear = ($urandom % 4 != 0);
      chg_en = ($urandom % 3 != 0);
      chg_fet = ($urandom % 3 != 0);
      cur = 16'($signed($urandom_range(0, 100)) - 50);
      @(posedge clk);
      #2;
    end
    trip = '0; host = 1'b0; load = 1'b0;
    idle(3);
    finish_run();
  end
endmodule